// File: doc/BRIEF.md
# Hashed Direct-Mapped Instruction Translation Table

This block sits in a processor front end and turns instruction fetch effective addresses into real addresses. It uses a direct-mapped table of translation entries. A slot is chosen by folding three adjacent fields of the page number together with XOR. The fetch unit sends a request with an effective address. One clock later the block returns the real address, a hit flag and a fetch-failed flag. A failed fetch is reported, not stalled, so the pipeline can turn it into an instruction storage exception further down.

Two flags shape a lookup: translation on or off, and privileged or not. They are captured only when a redirect is presented, so a mode change takes effect at the next redirect. A fill port writes one entry from an address and a page-table entry. An entry that no context could execute is refused. An invalidate port clears the slot that an address hashes to, without checking whose translation sits there.

Top module: `itlb_top`

## Requirements
- R1: Reset clears the valid bit of every slot, and after reset no response is presented until a request arrives.
- R2: A request presented in one cycle produces `rsp_valid_o` = 1 in the next cycle. A cycle without a request produces `rsp_valid_o`, `hit_o` and `fail_o` all 0 one cycle later.
- R3: The slot index is EA[12+I-1:12] XOR EA[12+2I-1:12+I] XOR EA[12+3I-1:12+2I], where I = log2(ENTRIES). The default is I = 6, giving fields 17:12, 23:18 and 29:24.
- R4: With translation on, a hit needs the indexed slot to be valid and its stored tag to equal EA[63:12+3I]. On a hit, `ra_o` = {PTE[55:12], EA[11:0]} (4 KiB pages).
- R5: With translation on and no hit, `hit_o` = 0, `fail_o` = 1 and `ra_o` = 0.
- R6: With translation off, `ra_o` = EA[55:0], `hit_o` = 1 and `fail_o` = 0, whatever the table holds.
- R7: PTE bit 3 marks an entry as privileged-only. A hit on such an entry while the captured privilege flag is 0 gives `hit_o` = 1 and `fail_o` = 1. In privileged mode the same hit gives `fail_o` = 0.
- R8: A fill whose PTE has bit 0 clear or bit 8 clear is ignored. The slot keeps its previous contents and validity.
- R9: An invalidate clears the slot its address hashes to, even when the stored tag differs. If a fill and an invalidate hit the same slot in one cycle, the slot ends up invalid.
- R10: `virt_en_i` and `priv_i` are sampled only in a cycle with `redir_i` = 1. A request in that same cycle already uses the new values. Changes at any other time have no effect.
- R11: A fill or invalidate changes the result of lookups issued in later cycles. A lookup issued in the same cycle sees the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| redir_i | input | 1 | Redirect; captures the mode flags |
| virt_en_i | input | 1 | Translation enable, sampled on redirect |
| priv_i | input | 1 | Privileged fetch, sampled on redirect |
| req_i | input | 1 | Lookup request |
| ea_i | input | 64 | Lookup effective address |
| ld_i | input | 1 | Fill request |
| ld_ea_i | input | 64 | Fill effective address |
| ld_pte_i | input | 64 | Fill page-table entry |
| inv_i | input | 1 | Invalidate request |
| inv_ea_i | input | 64 | Invalidate effective address |
| rsp_valid_o | output | 1 | Response valid, one cycle after request |
| ra_o | output | 56 | Real address |
| hit_o | output | 1 | Translation found (or translation off) |
| fail_o | output | 1 | Fetch failed (miss or privilege violation) |

## Verification
The bench fills every slot and places the index bits in each of the three hash fields in turn. A design that hashed the wrong field, or only one field, would then miss or hit the wrong slot. It builds aliases: addresses that share a slot but not a tag, and addresses whose different fields XOR to the same index. A missing tag compare shows up as a false hit, and an invalidate that compares tags shows up as a stale hit. It also covers refused fills with either permission bit clear, the privilege bit in both modes, and mode flags that change without a redirect (a design that ignores the redirect would switch translation at once). Finally it issues a fill together with a lookup in the same cycle, and a fill together with an invalidate of the same slot, to pin down ordering.

// File: rtl/itlb_pkg.sv
package itlb_pkg;

    localparam int EA_W     = 64;
    localparam int RA_W     = 56;
    localparam int PTE_W    = 64;
    localparam int PAGE_SH  = 12;
    localparam int HASH_MAX = 16;

    // page-table entry bit positions the block decodes
    localparam int PTE_EXEC_BIT = 0;
    localparam int PTE_PRIV_BIT = 3;
    localparam int PTE_REF_BIT  = 8;

    typedef struct packed {
        logic virt;
        logic priv;
    } fetch_mode_t;

    typedef struct packed {
        logic            hit;
        logic            fail;
        logic [RA_W-1:0] ra;
    } xlate_rsp_t;

    // fold three index-wide fields above the page offset with XOR
    function automatic logic [HASH_MAX-1:0] hash_index(input logic [EA_W-1:0] ea,
                                                       input int unsigned idx_w);
        logic [EA_W-1:0] mask;
        logic [EA_W-1:0] folded;
        mask   = (64'd1 << idx_w) - 64'd1;
        folded = (ea >> PAGE_SH) ^ (ea >> (PAGE_SH + idx_w)) ^ (ea >> (PAGE_SH + 2 * idx_w));
        return HASH_MAX'(folded & mask);
    endfunction

    function automatic logic pte_executable(input logic [PTE_W-1:0] pte);
        return pte[PTE_EXEC_BIT] & pte[PTE_REF_BIT];
    endfunction

endpackage

// File: rtl/itlb_mode_reg.sv
module itlb_mode_reg
    import itlb_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        redir_i,
    input  logic        virt_en_i,
    input  logic        priv_i,
    output fetch_mode_t mode_q_o,
    output fetch_mode_t mode_eff_o
);

    fetch_mode_t mode_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
        end else if (redir_i) begin
            mode_q.virt <= virt_en_i;
            mode_q.priv <= priv_i;
        end
    end

    // a request that travels with the redirect already sees the new flags
    always_comb begin
        if (redir_i) begin
            mode_eff_o.virt = virt_en_i;
            mode_eff_o.priv = priv_i;
        end else begin
            mode_eff_o = mode_q;
        end
    end

    assign mode_q_o = mode_q;

endmodule

// File: rtl/itlb_array.sv
module itlb_array #(
    parameter int ENTRIES = 64,
    parameter int TAG_W   = 34,
    parameter int RPN_W   = 44
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [$clog2(ENTRIES)-1:0] rd_idx_i,
    output logic                       rd_valid_o,
    output logic [TAG_W-1:0]           rd_tag_o,
    output logic [RPN_W-1:0]           rd_rpn_o,
    output logic                       rd_priv_o,
    input  logic                       wr_en_i,
    input  logic [$clog2(ENTRIES)-1:0] wr_idx_i,
    input  logic [TAG_W-1:0]           wr_tag_i,
    input  logic [RPN_W-1:0]           wr_rpn_i,
    input  logic                       wr_priv_i,
    input  logic                       inv_en_i,
    input  logic [$clog2(ENTRIES)-1:0] inv_idx_i,
    output logic [ENTRIES-1:0]         valid_o
);

    localparam int IDX_W = $clog2(ENTRIES);

    logic [ENTRIES-1:0] valid_q;
    logic [TAG_W-1:0]   tag_q  [ENTRIES];
    logic [RPN_W-1:0]   rpn_q  [ENTRIES];
    logic               priv_q [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        logic wr_here;
        logic inv_here;
        assign wr_here  = wr_en_i  && (wr_idx_i  == IDX_W'(g));
        assign inv_here = inv_en_i && (inv_idx_i == IDX_W'(g));

        // invalidate takes precedence over a fill of the same slot
        always_ff @(posedge clk) begin
            if (rst) begin
                valid_q[g] <= 1'b0;
            end else if (inv_here) begin
                valid_q[g] <= 1'b0;
            end else if (wr_here) begin
                valid_q[g] <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (wr_here) begin
                tag_q[g]  <= wr_tag_i;
                rpn_q[g]  <= wr_rpn_i;
                priv_q[g] <= wr_priv_i;
            end
        end
    end

    assign rd_valid_o = valid_q[rd_idx_i];
    assign rd_tag_o   = tag_q[rd_idx_i];
    assign rd_rpn_o   = rpn_q[rd_idx_i];
    assign rd_priv_o  = priv_q[rd_idx_i];
    assign valid_o    = valid_q;

endmodule

// File: rtl/itlb_lookup.sv
module itlb_lookup
    import itlb_pkg::*;
#(
    parameter int TAG_W = 34,
    parameter int RPN_W = 44
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_i,
    input  logic [EA_W-1:0]   ea_i,
    input  fetch_mode_t       mode_i,
    input  logic              slot_valid_i,
    input  logic [TAG_W-1:0]  slot_tag_i,
    input  logic [RPN_W-1:0]  slot_rpn_i,
    input  logic              slot_priv_i,
    output logic              rsp_valid_o,
    output xlate_rsp_t        rsp_o,
    output logic              virt_used_o
);

    localparam int TAG_LSB = EA_W - TAG_W;

    xlate_rsp_t rsp_d;
    xlate_rsp_t rsp_q;
    logic       valid_q;
    logic       virt_q;
    logic       tag_match;

    assign tag_match = slot_valid_i && (slot_tag_i == ea_i[EA_W-1:TAG_LSB]);

    always_comb begin
        rsp_d = '0;
        if (req_i) begin
            if (!mode_i.virt) begin
                rsp_d.hit  = 1'b1;
                rsp_d.fail = 1'b0;
                rsp_d.ra   = ea_i[RA_W-1:0];
            end else if (tag_match) begin
                rsp_d.hit  = 1'b1;
                rsp_d.fail = slot_priv_i && !mode_i.priv;
                rsp_d.ra   = {slot_rpn_i, ea_i[PAGE_SH-1:0]};
            end else begin
                rsp_d.hit  = 1'b0;
                rsp_d.fail = 1'b1;
                rsp_d.ra   = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_q   <= '0;
            valid_q <= 1'b0;
            virt_q  <= 1'b0;
        end else begin
            rsp_q   <= rsp_d;
            valid_q <= req_i;
            virt_q  <= req_i && mode_i.virt;
        end
    end

    assign rsp_valid_o = valid_q;
    assign rsp_o       = rsp_q;
    assign virt_used_o = virt_q;

endmodule

// File: rtl/itlb_top.sv
module itlb_top
    import itlb_pkg::*;
#(
    parameter int ENTRIES = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            redir_i,
    input  logic            virt_en_i,
    input  logic            priv_i,
    input  logic            req_i,
    input  logic [63:0]     ea_i,
    input  logic            ld_i,
    input  logic [63:0]     ld_ea_i,
    input  logic [63:0]     ld_pte_i,
    input  logic            inv_i,
    input  logic [63:0]     inv_ea_i,
    output logic            rsp_valid_o,
    output logic [55:0]     ra_o,
    output logic            hit_o,
    output logic            fail_o
);

    localparam int IDX_W   = $clog2(ENTRIES);
    localparam int TAG_LSB = PAGE_SH + 3 * IDX_W;
    localparam int TAG_W   = EA_W - TAG_LSB;
    localparam int RPN_W   = RA_W - PAGE_SH;

    fetch_mode_t        mode_q;
    fetch_mode_t        mode_eff;
    logic [IDX_W-1:0]   rd_idx;
    logic [IDX_W-1:0]   ld_idx;
    logic [IDX_W-1:0]   inv_idx;
    logic               ld_accept;
    logic               slot_valid;
    logic [TAG_W-1:0]   slot_tag;
    logic [RPN_W-1:0]   slot_rpn;
    logic               slot_priv;
    logic [ENTRIES-1:0] valid_vec;
    logic               lk_virt_q;
    xlate_rsp_t         rsp;
    logic               unused_in_bits;

    assign rd_idx    = IDX_W'(hash_index(ea_i, IDX_W));
    assign ld_idx    = IDX_W'(hash_index(ld_ea_i, IDX_W));
    assign inv_idx   = IDX_W'(hash_index(inv_ea_i, IDX_W));
    assign ld_accept = ld_i && pte_executable(ld_pte_i);

    assign unused_in_bits = ^{ld_ea_i[PAGE_SH-1:0], ld_pte_i[PTE_W-1:RA_W],
                              ld_pte_i[PAGE_SH-1:0], inv_ea_i[EA_W-1:TAG_LSB],
                              inv_ea_i[PAGE_SH-1:0], mode_q};

    itlb_mode_reg u_mode (
        .clk        (clk),
        .rst        (rst),
        .redir_i    (redir_i),
        .virt_en_i  (virt_en_i),
        .priv_i     (priv_i),
        .mode_q_o   (mode_q),
        .mode_eff_o (mode_eff)
    );

    itlb_array #(
        .ENTRIES (ENTRIES),
        .TAG_W   (TAG_W),
        .RPN_W   (RPN_W)
    ) u_arr (
        .clk        (clk),
        .rst        (rst),
        .rd_idx_i   (rd_idx),
        .rd_valid_o (slot_valid),
        .rd_tag_o   (slot_tag),
        .rd_rpn_o   (slot_rpn),
        .rd_priv_o  (slot_priv),
        .wr_en_i    (ld_accept),
        .wr_idx_i   (ld_idx),
        .wr_tag_i   (ld_ea_i[EA_W-1:TAG_LSB]),
        .wr_rpn_i   (ld_pte_i[RA_W-1:PAGE_SH]),
        .wr_priv_i  (ld_pte_i[PTE_PRIV_BIT]),
        .inv_en_i   (inv_i),
        .inv_idx_i  (inv_idx),
        .valid_o    (valid_vec)
    );

    itlb_lookup #(
        .TAG_W (TAG_W),
        .RPN_W (RPN_W)
    ) u_lk (
        .clk          (clk),
        .rst          (rst),
        .req_i        (req_i),
        .ea_i         (ea_i),
        .mode_i       (mode_eff),
        .slot_valid_i (slot_valid),
        .slot_tag_i   (slot_tag),
        .slot_rpn_i   (slot_rpn),
        .slot_priv_i  (slot_priv),
        .rsp_valid_o  (rsp_valid_o),
        .rsp_o        (rsp),
        .virt_used_o  (lk_virt_q)
    );

    assign ra_o   = rsp.ra;
    assign hit_o  = rsp.hit;
    assign fail_o = rsp.fail;

endmodule

// File: rtl/itlb_checker.sv
module itlb_checker
    import itlb_pkg::*;
#(
    parameter int ENTRIES = 64
) (
    input logic               clk,
    input logic               rst,
    input logic               req_i,
    input logic               redir_i,
    input logic               ld_i,
    input logic [63:0]        ld_pte_i,
    input logic               inv_i,
    input logic [63:0]        inv_ea_i,
    input logic               rsp_valid_o,
    input logic               hit_o,
    input logic               fail_o,
    input logic [ENTRIES-1:0] valid_vec,
    input logic               virt_used,
    input fetch_mode_t        mode_q
);

    localparam int IDX_W = $clog2(ENTRIES);

    logic [IDX_W-1:0] chk_inv_idx;
    logic             bad_fill;
    logic             unused_chk;

    assign chk_inv_idx = IDX_W'(hash_index(inv_ea_i, IDX_W));
    assign bad_fill    = ld_i && !(ld_pte_i[PTE_EXEC_BIT] && ld_pte_i[PTE_REF_BIT]);
    assign unused_chk  = ^ld_pte_i;

    a_r1_reset_clears: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (valid_vec == '0 && !rsp_valid_o));

    a_r2_rsp_follows_req: assert property (@(posedge clk) disable iff (rst)
        req_i |=> rsp_valid_o);

    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !req_i |=> (!rsp_valid_o && !hit_o && !fail_o));

    a_r5_fail_in_rsp: assert property (@(posedge clk) disable iff (rst)
        fail_o |-> rsp_valid_o);

    a_r6_bypass_ok: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid_o && !virt_used) |-> (hit_o && !fail_o));

    a_r8_bad_fill_ignored: assert property (@(posedge clk) disable iff (rst)
        (bad_fill && !inv_i) |=> $stable(valid_vec));

    a_r9_inv_clears: assert property (@(posedge clk) disable iff (rst)
        inv_i |=> !valid_vec[$past(chk_inv_idx)]);

    a_r10_mode_hold: assert property (@(posedge clk) disable iff (rst)
        !redir_i |=> $stable(mode_q));

endmodule

bind itlb_top itlb_checker #(.ENTRIES(ENTRIES)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_i       (req_i),
    .redir_i     (redir_i),
    .ld_i        (ld_i),
    .ld_pte_i    (ld_pte_i),
    .inv_i       (inv_i),
    .inv_ea_i    (inv_ea_i),
    .rsp_valid_o (rsp_valid_o),
    .hit_o       (hit_o),
    .fail_o      (fail_o),
    .valid_vec   (valid_vec),
    .virt_used   (lk_virt_q),
    .mode_q      (mode_q)
);

// File: tb/tb_itlb_top.sv
`timescale 1ns/1ps
module tb_itlb_top;

    localparam int ENTRIES = 64;

    logic        clk = 1'b0;
    logic        rst;
    logic        redir_i, virt_en_i, priv_i, req_i, ld_i, inv_i;
    logic [63:0] ea_i, ld_ea_i, ld_pte_i, inv_ea_i;
    logic        rsp_valid_o, hit_o, fail_o;
    logic [55:0] ra_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    // bench model state
    bit          m_valid [ENTRIES];
    logic [63:0] m_ea    [ENTRIES];
    logic [63:0] m_pte   [ENTRIES];
    bit          m_virt, m_priv;

    always #2.5 clk = ~clk;

    itlb_top #(.ENTRIES(ENTRIES)) dut (
        .clk(clk), .rst(rst), .redir_i(redir_i), .virt_en_i(virt_en_i), .priv_i(priv_i),
        .req_i(req_i), .ea_i(ea_i), .ld_i(ld_i), .ld_ea_i(ld_ea_i), .ld_pte_i(ld_pte_i),
        .inv_i(inv_i), .inv_ea_i(inv_ea_i), .rsp_valid_o(rsp_valid_o), .ra_o(ra_o),
        .hit_o(hit_o), .fail_o(fail_o)
    );

    function automatic int slot_of(input logic [63:0] ea);
        logic [63:0] pg;
        pg = ea / 64'd4096;
        return int'((pg ^ (pg / 64'd64) ^ (pg / 64'd4096)) % ENTRIES);
    endfunction

    function automatic logic [63:0] good_pte(input logic [43:0] rpn, input bit privonly);
        return ({20'h0, rpn} * 64'd4096) + 64'h101 + (privonly ? 64'h8 : 64'h0);
    endfunction

    function automatic logic [63:0] mk_ea(input logic [33:0] tag, input int slot,
                                          input int field, input logic [11:0] off);
        return ({30'h0, tag} << 30) | (64'(slot) << (12 + 6 * field)) | {52'h0, off};
    endfunction

    // one cycle of stimulus; compares the response of any lookup issued in it
    task automatic cyc(input bit do_req, input logic [63:0] ea,
                       input bit do_ld, input logic [63:0] lea, input logic [63:0] lpte,
                       input bit do_inv, input logic [63:0] iea,
                       input bit do_redir, input bit v, input bit p, input string rq);
        bit          e_v, e_h, e_f, use_v, use_p;
        logic [55:0] e_ra;
        int          s;
        use_v = do_redir ? v : m_virt;
        use_p = do_redir ? p : m_priv;
        e_v = do_req; e_h = 0; e_f = 0; e_ra = '0;
        if (do_req) begin
            if (!use_v) begin
                e_h = 1; e_ra = ea[55:0];
            end else begin
                s = slot_of(ea);
                if (m_valid[s] && m_ea[s][63:30] == ea[63:30]) begin
                    e_h = 1;
                    e_f = m_pte[s][3] && !use_p;
                    e_ra = {m_pte[s][55:12], ea[11:0]};
                end else begin
                    e_f = 1;
                end
            end
        end
        req_i = do_req; ea_i = ea;
        ld_i = do_ld; ld_ea_i = lea; ld_pte_i = lpte;
        inv_i = do_inv; inv_ea_i = iea;
        redir_i = do_redir;
        if (do_redir) begin virt_en_i = v; priv_i = p; end
        @(negedge clk);
        req_i = 0; ld_i = 0; inv_i = 0; redir_i = 0;
        n_checks++;
        if (rsp_valid_o !== e_v || hit_o !== e_h || fail_o !== e_f || ra_o !== e_ra) begin
            n_fail++;
            $display("FAIL %s: ea=%h got v=%0b h=%0b f=%0b ra=%h exp v=%0b h=%0b f=%0b ra=%h",
                     rq, ea, rsp_valid_o, hit_o, fail_o, ra_o, e_v, e_h, e_f, e_ra);
        end
        if (do_redir) begin m_virt = v; m_priv = p; end
        if (do_ld && lpte[0] && lpte[8]) begin
            s = slot_of(lea); m_valid[s] = 1; m_ea[s] = lea; m_pte[s] = lpte;
        end
        if (do_inv) m_valid[slot_of(iea)] = 0;
    endtask

    task automatic look(input logic [63:0] ea, input string rq);
        cyc(1, ea, 0, '0, '0, 0, '0, 0, 0, 0, rq);
    endtask
    task automatic fill(input logic [63:0] ea, input logic [63:0] pte, input string rq);
        cyc(0, '0, 1, ea, pte, 0, '0, 0, 0, 0, rq);
    endtask
    task automatic inval(input logic [63:0] ea, input string rq);
        cyc(0, '0, 0, '0, '0, 1, ea, 0, 0, 0, rq);
    endtask
    task automatic redirect(input bit v, input bit p, input string rq);
        cyc(0, '0, 0, '0, '0, 0, '0, 1, v, p, rq);
    endtask

    initial begin
        for (int i = 0; i < ENTRIES; i++) begin m_valid[i] = 0; m_ea[i] = '0; m_pte[i] = '0; end
        m_virt = 0; m_priv = 0;
        rst = 1; redir_i = 0; virt_en_i = 0; priv_i = 0; req_i = 0; ld_i = 0; inv_i = 0;
        ea_i = '0; ld_ea_i = '0; ld_pte_i = '0; inv_ea_i = '0;
        repeat (3) @(negedge clk);
        rst = 0;
        // R1: idle after reset
        cyc(0, '0, 0, '0, '0, 0, '0, 0, 0, 0, "R1 reset idle");
        // R6, R2: translation off after reset
        look(64'hFEDC_BA98_7654_3210, "R6 bypass");
        look(64'h0000_0000_0000_0004, "R6 bypass low");
        cyc(0, '0, 0, '0, '0, 0, '0, 0, 0, 0, "R2 idle after req");
        // R10: request in the redirect cycle uses the new flags
        cyc(1, 64'h1234_5000, 0, '0, '0, 0, '0, 1, 1, 1, "R10 redirect same cycle");
        // R1, R5: every slot misses after reset
        for (int i = 0; i < ENTRIES; i++) look(mk_ea(34'(i + 3), i, 0, 12'h10), "R1 R5 empty sweep");
        // R3, R4: fill every slot, index placed in each hash field in turn
        for (int i = 0; i < ENTRIES; i++)
            fill(mk_ea(34'(i * 7 + 1), i, i % 3, 12'h0), good_pte(44'(i + 'h100), 0), "R3 fill");
        for (int i = 0; i < ENTRIES; i++)
            look(mk_ea(34'(i * 7 + 1), i, i % 3, 12'(i * 4 + 1)), "R3 R4 hit sweep");
        // R4, R5: same slot, other tag
        for (int i = 0; i < ENTRIES; i += 5)
            look(mk_ea(34'(i * 7 + 2), i, i % 3, 12'h0), "R4 R5 tag alias");
        // R3: two fields cancelling to the same slot
        look(mk_ea(34'(6 * 7 + 1), 6, 0, 0) | (64'h15 << 18) | (64'h15 << 24), "R3 xor fold");
        // R8: refused fills keep the old entry
        fill(mk_ea(34'h3333, 5, 1, 0), 64'h0000_0000_0055_5100, "R8 bit0 clear");
        fill(mk_ea(34'h3334, 5, 1, 0), 64'h0000_0000_0055_5001, "R8 bit8 clear");
        look(mk_ea(34'h3333, 5, 1, 0), "R8 refused not present");
        look(mk_ea(34'(5 * 7 + 1), 5, 5 % 3, 12'h7), "R8 old entry kept");
        // R7: privilege bit
        fill(mk_ea(34'h777, 9, 2, 0), good_pte(44'hABCDE, 1), "R7 fill priv");
        look(mk_ea(34'h777, 9, 2, 12'h44), "R7 priv ok");
        redirect(1, 0, "R7 to user");
        look(mk_ea(34'h777, 9, 2, 12'h44), "R7 user fails");
        look(mk_ea(34'(10 * 7 + 1), 10, 1, 12'h8), "R7 plain entry ok");
        // R10: flags change without redirect
        virt_en_i = 0; priv_i = 1;
        look(mk_ea(34'h777, 9, 2, 12'h0), "R10 no redirect priv");
        look(64'h0000_0AAA_0000_0000, "R10 no redirect virt");
        // R9: invalidate with other tag
        inval(mk_ea(34'h2_0000, 12, 0, 0), "R9 inval");
        look(mk_ea(34'(12 * 7 + 1), 12, 0, 0), "R9 cleared");
        look(mk_ea(34'(13 * 7 + 1), 13, 1, 0), "R9 neighbour kept");
        cyc(0, '0, 1, mk_ea(34'h55, 20, 0, 0), good_pte(44'h1, 0), 1, mk_ea(34'h66, 20, 1, 0),
            0, 0, 0, "R9 fill vs inval");
        look(mk_ea(34'h55, 20, 0, 0), "R9 inval wins");
        // R11: same-cycle fill is not seen
        cyc(1, mk_ea(34'h99, 30, 0, 0), 1, mk_ea(34'h99, 30, 0, 0), good_pte(44'h2, 0),
            0, '0, 0, 0, 0, "R11 same cycle");
        look(mk_ea(34'h99, 30, 0, 0), "R11 next cycle");
        // mixed random traffic
        for (int k = 0; k < 3000; k++) begin
            logic [63:0] a, b;
            a = {32'(0), 32'($urandom)} & 64'h0000_0000_7FFF_FFFF;
            a[33:30] = 4'($urandom % 3);
            b = {32'(0), 32'($urandom)} & 64'h0000_0000_3FFF_F000;
            b[33:30] = 4'($urandom % 3);
            cyc(1, a, ($urandom % 3) == 0, b,
                good_pte(44'($urandom), ($urandom % 4) == 0) & ~((($urandom % 6) == 0) ? 64'h1 : 64'h0),
                ($urandom % 8) == 0, a, ($urandom % 16) == 0, ($urandom % 4) != 0, $urandom % 2,
                "R4 R5 R7 R9 random");
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule